// File: doc/BRIEF.md
# Condition-Field Two-Input LUT Unit

This block keeps a small condition register made of eight 4-bit fields and applies one bitwise operation to them. The caller names three fields: a target, a first source and a table field. The table field holds a 4-entry truth table. For each bit position, the old target bit and the first-source bit together pick one table entry. A 4-bit mask decides which target bits take the picked entry. The target bits whose mask bit is clear keep their old values.

A load port writes any field directly, and a combinational read port shows any field. These two ports let a test environment set up operands and inspect results. An execute strobe starts the operation. The target field is rewritten at the clock edge that samples the strobe, and a one-cycle done pulse follows. Back-to-back strobes are accepted, one operation per cycle.

Top module: `cflut_unit`

## Requirements
- R1: A synchronous active-high reset sets all eight fields to 0000.
- R2: When `wrEn` is high at a rising edge, field `wrIdx` takes `wrData`. `rdData` always shows field `rdIdx` combinationally.
- R3: The table field's bit k is table entry k. For bit position i, the entry index is 2*(old target bit i) + (first-source bit i). For example, a target of 1111, a first source of 1100, a table of 1000 and a mask of 1111 give 1100.
- R4: Where mask bit i is 1, target bit i becomes the selected table entry.
- R5: Where mask bit i is 0, target bit i keeps its old value.
- R6: An operation changes no field other than the target.
- R7: All three operand values are taken from the register state before the write, so the result is correct when the target index equals the first-source index or the table index.
- R8: The target is updated at the rising edge that samples `exec` high. `done` is high for exactly the following cycle. Consecutive `exec` cycles each perform one operation, and each operation sees the result of the one before it.
- R9: If `exec` and `wrEn` are both high and `wrIdx` equals `tgtIdx`, the operation result is stored and the load is dropped. A load to any other field in that same cycle still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Load strobe |
| wrIdx | input | 3 | Field written by the load |
| wrData | input | 4 | Load value |
| rdIdx | input | 3 | Field shown on rdData |
| rdData | output | 4 | Value of field rdIdx |
| exec | input | 1 | Execute strobe |
| tgtIdx | input | 3 | Target field index |
| srcIdx | input | 3 | First-source field index |
| lutIdx | input | 3 | Table field index |
| mask | input | 4 | Per-bit write mask |
| done | output | 1 | One-cycle completion pulse |

## Verification
A load or an operation is visible on `rdData` one edge after its strobe, so the bench drives strobes on the falling edge and samples at the next falling edge. By that point exactly one rising edge has updated the field. `done` is sampled in the same slot, and again one cycle later to confirm it has dropped. In the back-to-back case the target is read after each of the two edges, which shows that the second operation used the first operation's result.

// File: rtl/cflut_pkg.sv
package cflut_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic doLoad;
    logic doExec;
  } ctrlStrobe_t;

  localparam int LUT_IDX_W = 2;
  localparam int LUT_ENTRIES = 1 << LUT_IDX_W;
endpackage

// File: rtl/cflut_ctrl.sv
module cflut_ctrl
  import cflut_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wrEn,
  input  logic        execReq,
  output ctrlStrobe_t strobes,
  output logic        done
);
  logic doneQ;

  always_comb begin
    strobes.doLoad = wrEn;
    strobes.doExec = execReq;
  end

  // Done follows the edge that performed the update
  always_ff @(posedge clk) begin
    if (rst) doneQ <= 1'b0;
    else     doneQ <= execReq;
  end

  assign done = doneQ;
endmodule

// File: rtl/cflut_datapath.sv
module cflut_datapath
  import cflut_pkg::*;
#(
  parameter int NUM_FIELDS = 8,
  parameter int FIELD_W    = 4,
  parameter int IDX_W      = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  ctrlStrobe_t        strobes,
  input  logic [IDX_W-1:0]   wrIdx,
  input  logic [FIELD_W-1:0] wrData,
  input  logic [IDX_W-1:0]   rdIdx,
  output logic [FIELD_W-1:0] rdData,
  input  logic [IDX_W-1:0]   tgtIdx,
  input  logic [IDX_W-1:0]   srcIdx,
  input  logic [IDX_W-1:0]   lutIdx,
  input  logic [FIELD_W-1:0] mask
);
  logic [FIELD_W-1:0] fieldQ [NUM_FIELDS];
  logic [FIELD_W-1:0] tgtOld, srcVal, tableVal, mergedVal;
  logic [LUT_ENTRIES-1:0] lutTable;

  // Operands are read from the state before any write
  always_comb begin
    tgtOld   = fieldQ[tgtIdx];
    srcVal   = fieldQ[srcIdx];
    tableVal = fieldQ[lutIdx];
    lutTable = tableVal[LUT_ENTRIES-1:0];
  end

  // One slice per bit position
  for (genvar b = 0; b < FIELD_W; b++) begin : g_bit
    logic [LUT_IDX_W-1:0] sel;
    assign sel = {tgtOld[b], srcVal[b]};
    assign mergedVal[b] = mask[b] ? lutTable[sel] : tgtOld[b];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NUM_FIELDS; k++) fieldQ[k] <= '0;
    end else begin
      if (strobes.doLoad) fieldQ[wrIdx] <= wrData;
      // Execute is written last so that it wins on the same field
      if (strobes.doExec) fieldQ[tgtIdx] <= mergedVal;
    end
  end

  assign rdData = fieldQ[rdIdx];
endmodule

// File: rtl/cflut_unit.sv
module cflut_unit
  import cflut_pkg::*;
#(
  parameter int NUM_FIELDS = 8,
  parameter int FIELD_W    = 4,
  localparam int IDX_W     = $clog2(NUM_FIELDS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wrEn,
  input  logic [IDX_W-1:0]   wrIdx,
  input  logic [FIELD_W-1:0] wrData,
  input  logic [IDX_W-1:0]   rdIdx,
  output logic [FIELD_W-1:0] rdData,
  input  logic               exec,
  input  logic [IDX_W-1:0]   tgtIdx,
  input  logic [IDX_W-1:0]   srcIdx,
  input  logic [IDX_W-1:0]   lutIdx,
  input  logic [FIELD_W-1:0] mask,
  output logic               done
);
  ctrlStrobe_t strobes;

  cflut_ctrl u_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .execReq(exec),
    .strobes(strobes), .done(done)
  );

  cflut_datapath #(
    .NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W), .IDX_W(IDX_W)
  ) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes),
    .wrIdx(wrIdx), .wrData(wrData), .rdIdx(rdIdx), .rdData(rdData),
    .tgtIdx(tgtIdx), .srcIdx(srcIdx), .lutIdx(lutIdx), .mask(mask)
  );
endmodule

// File: rtl/cflut_checker.sv
module cflut_checker #(
  parameter int FIELD_W = 4,
  parameter int IDX_W   = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               wrEn,
  input logic [IDX_W-1:0]   wrIdx,
  input logic [FIELD_W-1:0] wrData,
  input logic [IDX_W-1:0]   rdIdx,
  input logic [FIELD_W-1:0] rdData,
  input logic               exec,
  input logic [IDX_W-1:0]   tgtIdx,
  input logic [FIELD_W-1:0] mask,
  input logic               done
);
  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> rdData == '0); // R1

  AST_LOAD_VISIBLE: assert property (@(posedge clk) disable iff (rst)
    (wrEn && !(exec && tgtIdx == wrIdx)) |=>
      (rdIdx != $past(wrIdx)) || (rdData == $past(wrData))); // R2

  AST_MASK_KEEP: assert property (@(posedge clk) disable iff (rst)
    (exec && rdIdx == tgtIdx) |=>
      (rdIdx != $past(rdIdx)) ||
      (((rdData ^ $past(rdData)) & ~$past(mask)) == '0)); // R5

  AST_OTHERS_STABLE: assert property (@(posedge clk) disable iff (rst)
    (exec && rdIdx != tgtIdx && !(wrEn && wrIdx == rdIdx)) |=>
      (rdIdx != $past(rdIdx)) || $stable(rdData)); // R6

  AST_DONE_AFTER_EXEC: assert property (@(posedge clk) disable iff (rst)
    exec |=> done); // R8

  AST_DONE_ONLY_AFTER_EXEC: assert property (@(posedge clk) disable iff (rst)
    !exec |=> !done); // R8
endmodule

bind cflut_unit cflut_checker #(.FIELD_W(FIELD_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
  .rdIdx(rdIdx), .rdData(rdData), .exec(exec), .tgtIdx(tgtIdx),
  .mask(mask), .done(done)
);

// File: tb/tb_cflut_unit.sv
module tb_cflut_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wrEn = 1'b0;
  logic [2:0] wrIdx = '0, rdIdx = '0, tgtIdx = '0, srcIdx = '0, lutIdx = '0;
  logic [3:0] wrData = '0, mask = '0;
  logic exec = 1'b0;
  logic [3:0] rdData;
  logic done;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  cflut_unit dut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
    .rdIdx(rdIdx), .rdData(rdData), .exec(exec), .tgtIdx(tgtIdx),
    .srcIdx(srcIdx), .lutIdx(lutIdx), .mask(mask), .done(done)
  );

  // {target, source, table, mask, expected}
  localparam logic [19:0] VECS [9] = '{
    {4'b1111, 4'b1100, 4'b1000, 4'b1111, 4'b1100},
    {4'b1010, 4'b0110, 4'b0110, 4'b1111, 4'b1100},
    {4'b0101, 4'b0011, 4'b1110, 4'b1111, 4'b0111},
    {4'b1010, 4'b0110, 4'b0110, 4'b0011, 4'b1000},
    {4'b1001, 4'b0110, 4'b1111, 4'b0000, 4'b1001},
    {4'b0000, 4'b0000, 4'b1111, 4'b1111, 4'b1111},
    {4'b1111, 4'b1010, 4'b0000, 4'b1010, 4'b0101},
    {4'b1100, 4'b1010, 4'b0010, 4'b1111, 4'b0010},
    {4'b1100, 4'b1010, 4'b0100, 4'b1111, 4'b0100}
  };

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic readField(input logic [2:0] idx, output logic [3:0] val);
    rdIdx = idx;
    #1;
    val = rdData;
  endtask

  task automatic loadField(input logic [2:0] idx, input logic [3:0] val);
    @(negedge clk);
    wrEn = 1'b1; wrIdx = idx; wrData = val;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic runOp(input logic [2:0] t, input logic [2:0] s,
                       input logic [2:0] l, input logic [3:0] m);
    @(negedge clk);
    exec = 1'b1; tgtIdx = t; srcIdx = s; lutIdx = l; mask = m;
    @(negedge clk);
    exec = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] v;
    repeat (3) @(negedge clk);
    // R1: all fields zero after reset, done low
    for (int k = 0; k < 8; k++) begin
      readField(k[2:0], v);
      check("R1", v, 4'b0000);
    end
    check("R1 done", {3'b0, done}, 4'b0000);
    @(negedge clk);
    rst = 1'b0;

    // R2: load and read back
    loadField(3'd7, 4'b1011);
    readField(3'd7, v);
    check("R2", v, 4'b1011);

    // Vector table: R3 R4 R5 R6 R8
    for (int n = 0; n < 9; n++) begin
      loadField(3'd3, VECS[n][19:16]);
      loadField(3'd4, VECS[n][15:12]);
      loadField(3'd5, VECS[n][11:8]);
      runOp(3'd3, 3'd4, 3'd5, VECS[n][7:4]);
      check("R8 done", {3'b0, done}, 4'b0001);
      readField(3'd3, v);
      check("R3/R4/R5 result", v, VECS[n][3:0]);
      readField(3'd4, v);
      check("R6 source", v, VECS[n][15:12]);
      readField(3'd5, v);
      check("R6 table", v, VECS[n][11:8]);
      @(negedge clk);
      check("R8 done low", {3'b0, done}, 4'b0000);
    end
    readField(3'd7, v);
    check("R6 untouched", v, 4'b1011);

    // R7: target aliases table field
    loadField(3'd2, 4'b1010);
    loadField(3'd6, 4'b0110);
    runOp(3'd2, 3'd6, 3'd2, 4'b1111);
    readField(3'd2, v);
    check("R7 tgt=table", v, 4'b0110);

    // R7: target aliases source field
    loadField(3'd1, 4'b1010);
    loadField(3'd6, 4'b0001);
    runOp(3'd1, 3'd1, 3'd6, 4'b1111);
    readField(3'd1, v);
    check("R7 tgt=src", v, 4'b0101);

    // R8: back-to-back inversion
    loadField(3'd0, 4'b0000);
    loadField(3'd5, 4'b0011);
    rdIdx = 3'd0;
    @(negedge clk);
    exec = 1'b1; tgtIdx = 3'd0; srcIdx = 3'd4; lutIdx = 3'd5; mask = 4'b1111;
    @(negedge clk);
    check("R8 first", rdData, 4'b1111);
    check("R8 done1", {3'b0, done}, 4'b0001);
    @(negedge clk);
    exec = 1'b0;
    check("R8 second", rdData, 4'b0000);
    check("R8 done2", {3'b0, done}, 4'b0001);
    @(negedge clk);
    check("R8 done end", {3'b0, done}, 4'b0000);

    // R9: execute beats load on same field; other field load applies
    loadField(3'd3, 4'b0000);
    loadField(3'd5, 4'b1111);
    @(negedge clk);
    exec = 1'b1; tgtIdx = 3'd3; srcIdx = 3'd4; lutIdx = 3'd5; mask = 4'b1111;
    wrEn = 1'b1; wrIdx = 3'd3; wrData = 4'b0101;
    @(negedge clk);
    exec = 1'b0; wrEn = 1'b0;
    readField(3'd3, v);
    check("R9 same field", v, 4'b1111);
    @(negedge clk);
    exec = 1'b1; tgtIdx = 3'd3; mask = 4'b0000;
    wrEn = 1'b1; wrIdx = 3'd6; wrData = 4'b1001;
    @(negedge clk);
    exec = 1'b0; wrEn = 1'b0;
    readField(3'd6, v);
    check("R9 other field", v, 4'b1001);
    readField(3'd3, v);
    check("R9 masked target", v, 4'b1111);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule